// File: doc/BRIEF.md
# Protected Data EEPROM Access Controller

This block sits on a processor's byte-wide register bus and gives it access to a 1024-byte nonvolatile data array. Software sees five registers: a control register, a write-only unlock register, a data register, and a low and a high address register. A read of the array completes in one cycle. A write is guarded. The write-enable bit must already be set. The unlock register must first receive 0x55 and then 0xAA. Only after that does setting the write-start bit begin a programming interval of `PROG_CYCLES` clock cycles. While that interval runs, the registers refuse bus writes.

Two state machines carry the design. The unlock machine has the states `UL_IDLE`, `UL_GOT55` and `UL_ARMED`. It moves `UL_IDLE`→`UL_GOT55` on an unlock write of 0x55 and `UL_GOT55`→`UL_ARMED` on an unlock write of 0xAA. Every other bus write returns it to `UL_IDLE`: a write to any other register, a wrong unlock value, or any write in `UL_ARMED`. The programming machine has the states `WS_IDLE` and `WS_PROG`. It moves `WS_IDLE`→`WS_PROG` on an accepted start. It moves `WS_PROG`→`WS_IDLE` when its cycle counter reaches `PROG_CYCLES-1`; on that edge the array is written, write-start clears and the completion flag sets.

Register offsets on `bus_addr` are 0 control, 1 unlock, 2 data, 3 address low and 4 address high. The control bits are 7 space select (1 = program space), 4 completion flag, 2 write enable, 1 write start (busy) and 0 read strobe. All other bits read 0.

Top module: `nvm_access_ctrl`

## Requirements
- R1: The address low register holds 8 bits. The address high register (offset 4) keeps only bits 1:0, and its bits 7:2 always read 0.
- R2: A control write with bit 0 = 1 and bit 7 = 0 loads the data register from the array at {high,low}, readable in the next cycle. The read strobe bit reads 1 for exactly that one cycle. With bit 7 = 1 the data register is untouched and the strobe reads 0.
- R3: The data register keeps its value until a read strobe or a bus write to offset 2 changes it.
- R4: A start is accepted only when the last two bus writes were 0x55 and then 0xAA to the unlock register, immediately before the control write. A wrong value, a repeated 0x55 or a write to another register in between cancels the sequence. Each started write consumes the sequence.
- R5: Write start (control bit 1) is set only if write enable (bit 2) was already 1 before the control write. Setting both bits in one write leaves bit 1 clear.
- R6: Hardware never clears write enable; only a control write does.
- R7: While bit 1 is set, bus writes to the control, data and address registers have no effect.
- R8: After an accepted start, bit 1 reads 1 for exactly `PROG_CYCLES` cycles. The array location is written with the data register at the end of that interval.
- R9: At completion the flag (control bit 4) and the `done_irq` output set. They clear only on a control write with bit 4 = 0; a write with bit 4 = 1 leaves the flag set.
- R10: After reset every register and `done_irq` read 0, and the unlock register always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the register at `bus_addr` (combinational) |
| done_irq | output | 1 | Completion flag, level |

## Verification
The embedded properties check these rules on every cycle:
- the unlock machine reaches `UL_ARMED` only from `UL_GOT55`;
- a programming interval starts only from an armed sequence with write enable already set;
- the busy counter stays in range;
- registers hold still while busy;
- the read strobe is a single-cycle pulse;
- the flag stays sticky;
- write enable falls only on a software write.

The bench scenarios show the parts that depend on stored data and on the stimulus history. These are the exact busy length, counted against the clock, and the data returned after programming at two distinct addresses. They also cover which broken unlock orderings fail to start a write, and that ignored writes leave the register contents unchanged.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    localparam int BUS_AW = 3;

    localparam logic [BUS_AW-1:0] OFS_CTRL   = 3'd0;
    localparam logic [BUS_AW-1:0] OFS_UNLOCK = 3'd1;
    localparam logic [BUS_AW-1:0] OFS_DATA   = 3'd2;
    localparam logic [BUS_AW-1:0] OFS_ADRLO  = 3'd3;
    localparam logic [BUS_AW-1:0] OFS_ADRHI  = 3'd4;

    localparam int CB_SPACE = 7;
    localparam int CB_FLAG  = 4;
    localparam int CB_WEN   = 2;
    localparam int CB_START = 1;
    localparam int CB_READ  = 0;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_GOT55 = 2'd1,
        UL_ARMED = 2'd2
    } unlock_state_t;

    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_PROG = 1'b1
    } prog_state_t;
endpackage

// File: rtl/nvm_unlock_fsm.sv
module nvm_unlock_fsm
    import nvm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic       hit_unlock,
    input  logic [7:0] wdata,
    output logic       armed
);
    unlock_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (bus_we) begin
            if (!hit_unlock) begin
                state_d = UL_IDLE;
            end else begin
                unique case (state_q)
                    UL_IDLE:  state_d = (wdata == KEY_FIRST)  ? UL_GOT55 : UL_IDLE;
                    UL_GOT55: state_d = (wdata == KEY_SECOND) ? UL_ARMED : UL_IDLE;
                    UL_ARMED: state_d = UL_IDLE;
                    default:  state_d = UL_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        armed = (state_q == UL_ARMED);
    end

    AST_ARM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == UL_ARMED && $past(state_q) != UL_ARMED) |-> $past(state_q) == UL_GOT55); // R4
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer
    import nvm_pkg::*;
#(
    parameter int PROG_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

    prog_state_t     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE: if (start)         state_d = WS_PROG;
            WS_PROG: if (cnt_q == LAST) state_d = WS_IDLE;
            default: state_d = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == WS_PROG && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
            else                                     cnt_q <= '0;
        end
    end

    always_comb begin
        busy = (state_q == WS_PROG);
        done = (state_q == WS_PROG) && (cnt_q == LAST);
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(cnt_q) < PROG_CYCLES)); // R8
    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> cnt_q == '0); // R8
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int PROG_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              done_irq
);
    localparam int HI_W = ADDR_W - 8;

    logic            space_q, flag_q, wen_q, rstb_q;
    logic [7:0]      data_q, adr_lo_q;
    logic [HI_W-1:0] adr_hi_q;
    logic            armed, busy, done, start;
    logic [7:0]      cell_rd;
    logic            ctrl_wr, open_wr, rd_req;

    always_comb begin
        ctrl_wr = bus_we && (bus_addr == OFS_CTRL);
        open_wr = bus_we && !busy;
        rd_req  = ctrl_wr && !busy && bus_wdata[CB_READ] && !bus_wdata[CB_SPACE];
        start   = ctrl_wr && !busy && bus_wdata[CB_START] && !bus_wdata[CB_SPACE]
                  && wen_q && armed;
    end

    nvm_unlock_fsm u_unlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .hit_unlock (bus_addr == OFS_UNLOCK),
        .wdata      (bus_wdata),
        .armed      (armed)
    );

    nvm_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    nvm_store #(.ADDR_W(ADDR_W), .DATA_W(8)) u_store (
        .clk   (clk),
        .we    (done),
        .addr  ({adr_hi_q, adr_lo_q}),
        .wdata (data_q),
        .rdata (cell_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            space_q  <= 1'b0;
            flag_q   <= 1'b0;
            wen_q    <= 1'b0;
            rstb_q   <= 1'b0;
            data_q   <= '0;
            adr_lo_q <= '0;
            adr_hi_q <= '0;
        end else begin
            rstb_q <= rd_req;
            if (done) begin
                flag_q <= 1'b1;
            end else if (open_wr && bus_addr == OFS_CTRL && !bus_wdata[CB_FLAG]) begin
                flag_q <= 1'b0;
            end
            if (open_wr && bus_addr == OFS_CTRL) begin
                space_q <= bus_wdata[CB_SPACE];
                wen_q   <= bus_wdata[CB_WEN];
            end
            if (rd_req) begin
                data_q <= cell_rd;
            end else if (open_wr && bus_addr == OFS_DATA) begin
                data_q <= bus_wdata;
            end
            if (open_wr && bus_addr == OFS_ADRLO) adr_lo_q <= bus_wdata;
            if (open_wr && bus_addr == OFS_ADRHI) adr_hi_q <= bus_wdata[HI_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL:  bus_rdata = {space_q, 2'b00, flag_q, 1'b0, wen_q, busy, rstb_q};
            OFS_DATA:  bus_rdata = data_q;
            OFS_ADRLO: bus_rdata = adr_lo_q;
            OFS_ADRHI: bus_rdata = 8'(adr_hi_q);
            default:   bus_rdata = '0;
        endcase
        done_irq = flag_q;
    end

    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(armed && wen_q)); // R5
    AST_FROZEN_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(data_q) && $stable(adr_lo_q)
                                  && $stable(adr_hi_q) && $stable(wen_q))); // R7
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rstb_q |=> !rstb_q); // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(ctrl_wr && !busy && !bus_wdata[CB_FLAG])) |=> flag_q); // R9
    AST_WEN_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wen_q) |-> $past(ctrl_wr && !busy)); // R6
endmodule

// File: tb/tb_nvm_access_ctrl.sv
module tb_nvm_access_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PROG = 16;

    localparam logic [1:0] OP_W = 2'd0;
    localparam logic [1:0] OP_R = 2'd1;
    localparam logic [1:0] OP_I = 2'd2;

    localparam logic [2:0] CT = 3'd0;
    localparam logic [2:0] UL = 3'd1;
    localparam logic [2:0] DT = 3'd2;
    localparam logic [2:0] AL = 3'd3;
    localparam logic [2:0] AH = 3'd4;

    // {req[3:0], op[1:0], reg[2:0], data[7:0], expect[7:0]}
    localparam int NV = 47;
    localparam logic [24:0] VEC [NV] = '{
        {4'd1,  OP_W, AH, 8'h03, 8'h00},
        {4'd1,  OP_R, AH, 8'h00, 8'h03},  // R1
        {4'd1,  OP_W, AH, 8'hFF, 8'h00},
        {4'd1,  OP_R, AH, 8'h00, 8'h03},  // R1 upper bits zero
        {4'd1,  OP_W, AL, 8'h2A, 8'h00},
        {4'd8,  OP_W, DT, 8'h5A, 8'h00},
        {4'd8,  OP_W, CT, 8'h04, 8'h00},
        {4'd4,  OP_W, UL, 8'h55, 8'h00},
        {4'd4,  OP_W, UL, 8'hAA, 8'h00},
        {4'd8,  OP_W, CT, 8'h06, 8'h00},
        {4'd8,  OP_R, CT, 8'h00, 8'h06},  // R8 busy
        {4'd7,  OP_W, CT, 8'h00, 8'h00},
        {4'd7,  OP_W, DT, 8'h11, 8'h00},
        {4'd7,  OP_R, DT, 8'h00, 8'h5A},  // R7
        {4'd7,  OP_W, AL, 8'h00, 8'h00},
        {4'd7,  OP_R, AL, 8'h00, 8'h2A},  // R7
        {4'd8,  OP_I, CT, 8'd9,  8'h00},
        {4'd8,  OP_R, CT, 8'h00, 8'h06},  // R8 last busy cycle
        {4'd9,  OP_R, CT, 8'h00, 8'h14},  // R9 flag, R6 wen kept
        {4'd3,  OP_W, DT, 8'h00, 8'h00},
        {4'd2,  OP_W, CT, 8'h05, 8'h00},
        {4'd2,  OP_R, CT, 8'h00, 8'h05},  // R2 strobe
        {4'd2,  OP_R, CT, 8'h00, 8'h04},  // R2 strobe cleared
        {4'd2,  OP_R, DT, 8'h00, 8'h5A},  // R2 R8
        {4'd4,  OP_W, CT, 8'h06, 8'h00},
        {4'd4,  OP_R, CT, 8'h00, 8'h04},  // R4 sequence consumed
        {4'd5,  OP_W, CT, 8'h00, 8'h00},
        {4'd5,  OP_W, UL, 8'h55, 8'h00},
        {4'd5,  OP_W, UL, 8'hAA, 8'h00},
        {4'd5,  OP_W, CT, 8'h06, 8'h00},
        {4'd5,  OP_R, CT, 8'h00, 8'h04},  // R5
        {4'd4,  OP_W, UL, 8'h55, 8'h00},
        {4'd4,  OP_W, UL, 8'h55, 8'h00},
        {4'd4,  OP_W, UL, 8'hAA, 8'h00},
        {4'd4,  OP_W, CT, 8'h06, 8'h00},
        {4'd4,  OP_R, CT, 8'h00, 8'h04},  // R4 repeated key
        {4'd4,  OP_W, UL, 8'h55, 8'h00},
        {4'd4,  OP_W, DT, 8'h77, 8'h00},
        {4'd4,  OP_W, UL, 8'hAA, 8'h00},
        {4'd4,  OP_W, CT, 8'h06, 8'h00},
        {4'd4,  OP_R, CT, 8'h00, 8'h04},  // R4 interrupted
        {4'd3,  OP_W, DT, 8'h33, 8'h00},
        {4'd2,  OP_W, CT, 8'h81, 8'h00},
        {4'd3,  OP_R, DT, 8'h00, 8'h33},  // R3 R2 program space
        {4'd2,  OP_R, CT, 8'h00, 8'h80},  // R2
        {4'd2,  OP_W, CT, 8'h04, 8'h00},
        {4'd10, OP_R, UL, 8'h00, 8'h00}   // R10 unlock reads zero
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       done_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    nvm_access_ctrl #(.ADDR_W(10), .PROG_CYCLES(PROG)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .done_irq  (done_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic compare(input logic [7:0] act, input logic [7:0] exp, input int req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic [1:0] op, input logic [2:0] rg,
                        input logic [7:0] d, input logic [7:0] exp, input int req);
        @(negedge clk);
        bus_we   = (op == OP_W);
        bus_addr = rg;
        bus_wdata = d;
        if (op == OP_R) begin
            #1;
            compare(bus_rdata, exp, req);
        end else if (op == OP_I) begin
            bus_we = 1'b0;
            repeat (int'(d) - 1) @(negedge clk);
        end
    endtask

    task automatic irq_is(input logic exp, input int req);
        @(negedge clk);
        bus_we = 1'b0;
        #1;
        compare({7'd0, done_irq}, {7'd0, exp}, req);
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        step(OP_R, CT, 8'h00, 8'h00, 10);
        step(OP_R, DT, 8'h00, 8'h00, 10);
        step(OP_R, AL, 8'h00, 8'h00, 10);
        step(OP_R, AH, 8'h00, 8'h00, 10);
        irq_is(1'b0, 10);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][20:19], VEC[i][18:16], VEC[i][15:8], VEC[i][7:0], int'(VEC[i][24:21]));
        end

        // R8 R9 second programmed location, exact interval and irq timing
        step(OP_W, AH, 8'h00, 8'h00, 8);
        step(OP_W, AL, 8'h01, 8'h00, 8);
        step(OP_W, DT, 8'hC3, 8'h00, 8);
        step(OP_W, UL, 8'h55, 8'h00, 4);
        step(OP_W, UL, 8'hAA, 8'h00, 4);
        step(OP_W, CT, 8'h06, 8'h00, 8);
        step(OP_I, CT, 8'd15, 8'h00, 8);
        irq_is(1'b0, 8);                     // R8 not yet complete
        irq_is(1'b1, 9);                     // R9 flag at completion
        step(OP_W, CT, 8'h14, 8'h00, 9);
        irq_is(1'b1, 9);                     // R9 writing 1 keeps flag
        step(OP_W, CT, 8'h04, 8'h00, 9);
        irq_is(1'b0, 9);                     // R9 software clear
        step(OP_W, CT, 8'h05, 8'h00, 8);
        step(OP_R, DT, 8'h00, 8'hC3, 8);     // R8 new location
        step(OP_W, AH, 8'h03, 8'h00, 8);
        step(OP_W, AL, 8'h2A, 8'h00, 8);
        step(OP_W, CT, 8'h05, 8'h00, 8);
        step(OP_R, DT, 8'h00, 8'h5A, 8);     // R8 first location intact
        step(OP_R, CT, 8'h00, 8'h04, 6);     // R6 wen still set

        finished = 1'b1;
        report();
    end
endmodule